// File: doc/BRIEF.md
# Peripheral Idle Handshake Controller

This block sits between a peripheral core and the system power manager. It decides when the peripheral may acknowledge a request to go idle, and when the peripheral's interrupt and DMA request lines may reach the rest of the chip. The power manager raises an idle request. A two-bit mode input selects one of three policies: acknowledge unconditionally, acknowledge only if the core is quiet, or never acknowledge.

In the unconditional (force) policy, the block acknowledges one cycle after it sees the request. It then holds every request line low. Any bus access made while that idle is in effect is answered with an error. In the conditional (smart) policy, the block waits one cycle. If the core raises any interrupt or DMA event during the sampling cycle or the waiting cycle, the request is refused until the power manager withdraws it. When the request drops, the acknowledge clears on the next edge. The request lines stay masked for exactly one more cycle and then follow the core again. The block never alters the core's event levels. It only gates them.

Top module: `pwr_idle_hs`

## Requirements
- R1: With mode 2'b00 (force), an idle request sampled high while in the normal state raises `idle_ack_o` from the following cycle on, whatever the event inputs are.
- R2: While `idle_ack_o` is high, every bit of `irq_o` and `dma_o` is low, whatever the event inputs are.
- R3: Idle never clears core events. An event input held high through an idle period appears again on its output line once the masking ends.
- R4: When the idle request is low while acknowledged, `idle_ack_o` falls after the next edge. The request lines stay masked during that first cycle and follow the inputs from the cycle after.
- R5: With mode bit 1 set (2'b10 or 2'b11, smart), a request sampled with no event pending moves the block to a waiting state. If no event is pending in the waiting cycle, `idle_ack_o` rises one cycle later, which is two cycles after the request is first sampled.
- R6: In smart mode, any event that is high on the cycle the request is sampled, or during the waiting cycle, refuses the request. `idle_ack_o` then stays low for as long as the request is held, even after the events clear.
- R7: A refused request is released only when the idle request goes low. A later request is then handled afresh.
- R8: With mode 2'b01 (no idle), `idle_ack_o` never rises and the request lines pass straight through.
- R9: `bus_err_o` is high in the cycle after `bus_acc_i` is sampled high, but only if a force-mode acknowledge is in effect and the idle request is high. In every other case it stays low, including during a smart-mode acknowledge.
- R10: After the active-low reset, `idle_ack_o` and `bus_err_o` are low and the request lines pass through.
- R11: Outside idle and the one-cycle exit mask, `irq_o` and `dma_o` equal the event inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req_i | input | 1 | Idle request from the power manager |
| idle_mode_i | input | 2 | Idle policy: 00 force, 01 never, 1x smart |
| irq_evt_i | input | NIRQ | Interrupt request levels from the core |
| dma_evt_i | input | NDMA | DMA request levels from the core |
| bus_acc_i | input | 1 | Bus access strobe to the peripheral |
| idle_ack_o | output | 1 | Idle acknowledge to the power manager |
| irq_o | output | NIRQ | Gated interrupt request lines |
| dma_o | output | NDMA | Gated DMA request lines |
| bus_err_o | output | 1 | Error response for the sampled access |

## Verification
The request is tried under the force policy, under the smart policy with a quiet core, and under the smart policy with an event on the sampling cycle or on the waiting cycle. Each case tells apart a different path: acknowledge on the next edge, acknowledge after the extra wait, and refusal that lasts while the request is held. Events held across the idle period separate masking from clearing. The exit cycle is sampled on its own to show the single extra cycle of masking. Bus strobes are issued under force idle, under smart idle and in normal operation, and only the first case may answer with an error.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_SMART_WAIT = 2'd1,
    ST_IDLE_ACK   = 2'd2,
    ST_REFUSED    = 2'd3
  } idle_st_e;

  localparam logic [1:0] MODE_FORCE  = 2'b00;
  localparam logic [1:0] MODE_NOIDLE = 2'b01;

  function automatic logic mode_is_force(input logic [1:0] m);
    return m == MODE_FORCE;
  endfunction

  function automatic logic mode_is_smart(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/idle_hs_fsm.sv
module idle_hs_fsm
  import idle_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  logic [1:0] mode,
  input  logic       evt_any,
  output idle_st_e   st,
  output logic       ack,
  output logic       leave_ack,
  output logic       forced
);

  idle_st_e st_q, st_d;
  logic     forced_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (idle_req) begin
          if (mode_is_force(mode))      st_d = ST_IDLE_ACK;
          else if (mode_is_smart(mode)) st_d = evt_any ? ST_REFUSED : ST_SMART_WAIT;
        end
      end
      ST_SMART_WAIT: begin
        if (!idle_req)    st_d = ST_NORMAL;
        else if (evt_any) st_d = ST_REFUSED;
        else              st_d = ST_IDLE_ACK;
      end
      ST_IDLE_ACK: if (!idle_req) st_d = ST_NORMAL;
      ST_REFUSED:  if (!idle_req) st_d = ST_NORMAL;
      default:     st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_NORMAL;
      forced_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_NORMAL && st_d == ST_IDLE_ACK) forced_q <= 1'b1;
      else if (st_d != ST_IDLE_ACK)                 forced_q <= 1'b0;
    end
  end

  assign st        = st_q;
  assign ack       = (st_q == ST_IDLE_ACK);
  assign leave_ack = (st_q == ST_IDLE_ACK) && (st_d != ST_IDLE_ACK);
  assign forced    = forced_q;

  a_r1_force_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && idle_req && mode == MODE_FORCE) |=> ack);

  a_r6_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REFUSED && idle_req) |=> (st_q == ST_REFUSED && !ack));

  a_r5_smart_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack) && !forced_q) |-> ($past(st_q) == ST_SMART_WAIT));

  a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !idle_req) |=> !ack);

  a_r8_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && mode == MODE_NOIDLE) |=> (st_q == ST_NORMAL));

endmodule

// File: rtl/idle_hs_gate.sv
module idle_hs_gate #(
  parameter int NIRQ = 2,
  parameter int NDMA = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic            leave_ack,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NDMA-1:0] dma_in,
  output logic [NIRQ-1:0] irq_out,
  output logic [NDMA-1:0] dma_out
);

  logic hold_q;
  logic mask;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= leave_ack;
  end

  assign mask = ack | hold_q;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign irq_out[i] = irq_in[i] & ~mask;
  end
  for (genvar j = 0; j < NDMA; j++) begin : g_dma
    assign dma_out[j] = dma_in[j] & ~mask;
  end

  a_r2_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (irq_out == '0 && dma_out == '0));

endmodule

// File: rtl/idle_hs_buserr.sv
module idle_hs_buserr (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_acc,
  input  logic idle_req,
  input  logic ack,
  input  logic forced,
  output logic bus_err
);

  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bus_acc & idle_req & ack & forced;
  end

  assign bus_err = err_q;

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(bus_acc) && $past(idle_req)));

endmodule

// File: rtl/pwr_idle_hs.sv
module pwr_idle_hs
  import idle_hs_pkg::*;
#(
  parameter int NIRQ = 2,
  parameter int NDMA = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_req_i,
  input  logic [1:0]      idle_mode_i,
  input  logic [NIRQ-1:0] irq_evt_i,
  input  logic [NDMA-1:0] dma_evt_i,
  input  logic            bus_acc_i,
  output logic            idle_ack_o,
  output logic [NIRQ-1:0] irq_o,
  output logic [NDMA-1:0] dma_o,
  output logic            bus_err_o
);

  idle_st_e st;
  logic     evt_any;
  logic     ack;
  logic     leave_ack;
  logic     forced;

  assign evt_any = (|irq_evt_i) | (|dma_evt_i);

  idle_hs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_req  (idle_req_i),
    .mode      (idle_mode_i),
    .evt_any   (evt_any),
    .st        (st),
    .ack       (ack),
    .leave_ack (leave_ack),
    .forced    (forced)
  );

  idle_hs_gate #(.NIRQ(NIRQ), .NDMA(NDMA)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .leave_ack (leave_ack),
    .irq_in    (irq_evt_i),
    .dma_in    (dma_evt_i),
    .irq_out   (irq_o),
    .dma_out   (dma_o)
  );

  idle_hs_buserr u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_acc  (bus_acc_i),
    .idle_req (idle_req_i),
    .ack      (ack),
    .forced   (forced),
    .bus_err  (bus_err_o)
  );

  assign idle_ack_o = ack;

  a_r4_exit_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_ack_o) |-> (irq_o == '0 && dma_o == '0));

  a_r9_no_err_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_ack_o |=> !bus_err_o);

  a_r6_no_ack_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SMART_WAIT && evt_any) |=> !idle_ack_o);

endmodule

// File: tb/sim_pwr_idle_hs.sv
`timescale 1ns/1ps
module sim_pwr_idle_hs;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       idle_req_i;
  logic [1:0] idle_mode_i;
  logic [1:0] irq_evt_i;
  logic [1:0] dma_evt_i;
  logic       bus_acc_i;
  logic       idle_ack_o;
  logic [1:0] irq_o;
  logic [1:0] dma_o;
  logic       bus_err_o;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwr_idle_hs #(.NIRQ(2), .NDMA(2)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req_i), .idle_mode_i(idle_mode_i),
    .irq_evt_i(irq_evt_i), .dma_evt_i(dma_evt_i), .bus_acc_i(bus_acc_i),
    .idle_ack_o(idle_ack_o), .irq_o(irq_o), .dma_o(dma_o), .bus_err_o(bus_err_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic quiet();
    idle_req_i = 0; irq_evt_i = 0; dma_evt_i = 0; bus_acc_i = 0;
    nxt(); nxt();
  endtask

  task automatic t_reset();
    rst_n = 0; idle_req_i = 0; idle_mode_i = 2'b00;
    irq_evt_i = 0; dma_evt_i = 0; bus_acc_i = 0;
    nxt(); nxt();
    rst_n = 1; nxt();
    chk(idle_ack_o == 0, "R10 ack after reset", idle_ack_o, 0);
    chk(bus_err_o == 0, "R10 err after reset", bus_err_o, 0);
    irq_evt_i = 2'b10; dma_evt_i = 2'b01; #1;
    chk(irq_o == 2'b10, "R11 irq pass", irq_o, 2);
    chk(dma_o == 2'b01, "R11 dma pass", dma_o, 1);
    irq_evt_i = 0; dma_evt_i = 0;
  endtask

  task automatic t_force();
    idle_mode_i = 2'b00; irq_evt_i = 2'b01; idle_req_i = 1;
    nxt();
    chk(idle_ack_o == 1, "R1 force ack next cycle", idle_ack_o, 1);
    irq_evt_i = 2'b11; dma_evt_i = 2'b11; #1;
    chk(irq_o == 0 && dma_o == 0, "R2 lines masked", {irq_o, dma_o}, 0);
    bus_acc_i = 1; nxt(); bus_acc_i = 0;
    chk(bus_err_o == 1, "R9 force access error", bus_err_o, 1);
    nxt();
    chk(bus_err_o == 0, "R9 error clears", bus_err_o, 0);
    idle_req_i = 0; nxt();
    chk(idle_ack_o == 0, "R4 ack falls", idle_ack_o, 0);
    chk(irq_o == 0 && dma_o == 0, "R4 exit cycle masked", {irq_o, dma_o}, 0);
    nxt();
    chk(irq_o == 2'b11 && dma_o == 2'b11, "R3 held events return", {irq_o, dma_o}, 15);
    bus_acc_i = 1; nxt(); bus_acc_i = 0;
    chk(bus_err_o == 0, "R9 no error when awake", bus_err_o, 0);
    quiet();
  endtask

  task automatic t_smart_ok();
    idle_mode_i = 2'b10; idle_req_i = 1;
    nxt();
    chk(idle_ack_o == 0, "R5 no ack while waiting", idle_ack_o, 0);
    nxt();
    chk(idle_ack_o == 1, "R5 smart ack after wait", idle_ack_o, 1);
    dma_evt_i = 2'b10; #1;
    chk(dma_o == 0, "R2 smart no new request", dma_o, 0);
    bus_acc_i = 1; nxt(); bus_acc_i = 0;
    chk(bus_err_o == 0, "R9 no error in smart idle", bus_err_o, 0);
    idle_req_i = 0; nxt(); nxt();
    chk(dma_o == 2'b10, "R3 smart event returns", dma_o, 2);
    quiet();
  endtask

  task automatic t_smart_refuse_wait();
    idle_mode_i = 2'b11; idle_req_i = 1;
    nxt();
    dma_evt_i = 2'b01; #1;
    chk(dma_o == 2'b01, "R6 event passes in wait", dma_o, 1);
    nxt();
    dma_evt_i = 0;
    for (int k = 0; k < 4; k++) nxt();
    chk(idle_ack_o == 0, "R6 refused stays low", idle_ack_o, 0);
    idle_req_i = 0; nxt();
    idle_req_i = 1; nxt(); nxt();
    chk(idle_ack_o == 1, "R7 fresh request acked", idle_ack_o, 1);
    quiet();
  endtask

  task automatic t_smart_refuse_at_sample();
    idle_mode_i = 2'b10; irq_evt_i = 2'b10; idle_req_i = 1;
    nxt();
    irq_evt_i = 0;
    for (int k = 0; k < 3; k++) nxt();
    chk(idle_ack_o == 0, "R6 refused at sample", idle_ack_o, 0);
    quiet();
  endtask

  task automatic t_noidle();
    idle_mode_i = 2'b01; idle_req_i = 1;
    for (int k = 0; k < 4; k++) nxt();
    chk(idle_ack_o == 0, "R8 never acks", idle_ack_o, 0);
    irq_evt_i = 2'b01; #1;
    chk(irq_o == 2'b01, "R8 lines pass", irq_o, 1);
    quiet();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_force();
        t_smart_ok();
        t_smart_refuse_wait();
        t_smart_refuse_at_sample();
        t_noidle();
      end
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule